// File: doc/BRIEF.md
# Buffered Memory-to-Peripheral DMA Sequencer

This block sequences one dual-address DMA channel that moves a programmed number of bytes from memory to a peripheral through an internal staging buffer. Memory is read in large chunks, up to a maximum fetch size. The peripheral is fed in smaller slices of a fixed destination size, one slice for each request strobe it raises. The buffer contents are tracked as an occupancy count, because the data path itself lies outside this block.

When a request arrives and the buffer cannot supply a full slice, the sequencer starts a memory refill. It then issues one peripheral write straight away, without waiting for another request. The refill and that write form one unit that cannot be split. The peripheral may end the run early with a one-cycle stop pulse. The sequencer finishes any unit already under way and serves at most one request that has not yet been served. It then stops and discards whatever is left in the buffer.

Each transfer is presented on a simple request/acknowledge bus stub. The stub carries the transfer kind and its byte count, and both are held until the acknowledge arrives. The acknowledge strobe marks peripheral writes only.

Top module: `dmaSeqTop`

## Requirements
- R1: Out of reset `busyOut`, `busReq`, `dbb`, `dack` and `doneOut` are 0. A `startPulse` with a non-zero `totalBytes` raises `busyOut` on the next cycle. No bus request appears while the channel is idle.
- R2: A `dreq` that finds fewer than DST bytes in the buffer, while memory bytes remain unfetched, starts a memory read (`busMemRead`=1, `dack`=0) of min(MAX_SRC, unfetched bytes).
- R3: Once a memory read is acknowledged, a peripheral write of min(DST, occupancy) bytes is requested on the next cycle without any further `dreq`.
- R4: A `dreq` that finds at least DST bytes in the buffer starts only a peripheral write of DST bytes, with no memory read.
- R5: `dack` is 1 only while a peripheral write is requested. `dbb` is 1 for every requested transfer. A request holds its kind and byte count until `busAck`. Each serviced `dreq` produces exactly the transfers of its unit.
- R6: A refill never reads beyond the programmed count, so the final fetch may be shorter than MAX_SRC.
- R7: The channel goes idle after the write that completes `totalBytes`. `doneOut` is 1 together with `dack` during that final write only when `dstDoneEn` is 1.
- R8: A `doneIn` that arrives during a memory read still lets the read and its following peripheral write complete. The channel then stops.
- R9: A `doneIn` while the channel waits with no request outstanding stops it with no further transfer. Leftover buffer bytes are discarded, so the next run begins with a memory read.
- R10: A `doneIn` that arrives with one unserviced `dreq` (raised earlier or in the same cycle) lets that request be serviced, and the channel then stops. Requests raised after the `doneIn` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Starts a run using `totalBytes` |
| totalBytes | input | CNT_W | Programmed byte count of the run |
| dstDoneEn | input | 1 | Enables internal done on the final peripheral write |
| dreq | input | 1 | Peripheral transfer request strobe |
| doneIn | input | 1 | External one-cycle stop pulse |
| busAck | input | 1 | Bus stub acknowledge of the requested transfer |
| busReq | output | 1 | Bus stub transfer request |
| busMemRead | output | 1 | 1 = memory read, 0 = peripheral write |
| busBytes | output | XFER_W | Byte count of the requested transfer |
| dack | output | 1 | Peripheral acknowledge, peripheral writes only |
| dbb | output | 1 | Data bus busy |
| doneOut | output | 1 | Internal done, mirrors `dack` on the final write |
| busyOut | output | 1 | Channel active |

## Verification
The stop pulse can coincide with the channel's request handling in two ways: it can arrive in the same cycle as a new `dreq`, or while a memory read is still waiting for its acknowledge. The bench provokes the first case by pulsing `doneIn` and `dreq` together while the channel waits. It provokes the second by holding back `busAck` on a refill and pulsing `doneIn` during that read. In both cases the logged transfers are compared with the unit the completion rules allow, and `busyOut` must then fall. A full sweep of programmed counts checks every transfer kind and size against an arithmetic model of buffer occupancy.

// File: rtl/dmaSeqPkg.sv
package dmaSeqPkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_FETCH = 2'd2,
    ST_SEND  = 2'd3
  } seqState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;      // begin a run: load counts, empty buffer
    logic fetchAck;  // memory read finished
    logic sendAck;   // peripheral write finished
    logic flush;     // stop: discard buffer and counts
  } seqStrobe_t;

endpackage

// File: rtl/dmaSeqDatapath.sv
module dmaSeqDatapath
  import dmaSeqPkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int MAX_SRC = 32,
  parameter int DST     = 4,
  parameter int XFER_W  = $clog2(MAX_SRC + 1),
  parameter int OCC_W   = $clog2(MAX_SRC + DST)
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [CNT_W-1:0]  totalBytes,
  output logic [XFER_W-1:0] fetchBytes,
  output logic [XFER_W-1:0] sendBytes,
  output logic              needRefill,
  output logic              finalSend
);

  localparam logic [CNT_W-1:0] MAX_SRC_C = CNT_W'(MAX_SRC);
  localparam logic [OCC_W-1:0] DST_OCC   = OCC_W'(DST);

  logic [CNT_W-1:0] fetchLeft;
  logic [CNT_W-1:0] writeLeft;
  logic [OCC_W-1:0] occupancy;

  // Refill size is clipped to the bytes not yet fetched
  always_comb begin
    if (fetchLeft >= MAX_SRC_C) fetchBytes = XFER_W'(MAX_SRC);
    else                        fetchBytes = XFER_W'(fetchLeft);
  end

  // A slice is DST bytes, or the remainder at the tail of a run
  always_comb begin
    if (occupancy >= DST_OCC) sendBytes = XFER_W'(DST);
    else                      sendBytes = XFER_W'(occupancy);
  end

  assign needRefill = (occupancy < DST_OCC) && (fetchLeft != '0);
  assign finalSend  = (writeLeft == CNT_W'(sendBytes));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fetchLeft <= '0;
      writeLeft <= '0;
      occupancy <= '0;
    end else if (strobe.flush) begin
      fetchLeft <= '0;
      writeLeft <= '0;
      occupancy <= '0;
    end else if (strobe.load) begin
      fetchLeft <= totalBytes;
      writeLeft <= totalBytes;
      occupancy <= '0;
    end else if (strobe.fetchAck) begin
      fetchLeft <= fetchLeft - CNT_W'(fetchBytes);
      occupancy <= occupancy + OCC_W'(fetchBytes);
    end else if (strobe.sendAck) begin
      writeLeft <= writeLeft - CNT_W'(sendBytes);
      occupancy <= occupancy - OCC_W'(sendBytes);
    end
  end

endmodule

// File: rtl/dmaSeqControl.sv
module dmaSeqControl
  import dmaSeqPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startPulse,
  input  logic       totalNonZero,
  input  logic       dreq,
  input  logic       doneIn,
  input  logic       busAck,
  input  logic       needRefill,
  input  logic       finalSend,
  output seqStrobe_t strobe,
  output logic       busReq,
  output logic       busMemRead,
  output logic       busyOut
);

  seqState_t state, stateNext;
  logic      pend, pendNext;
  logic      stopPending, stopNext;
  logic      acceptReq, consume, stopNow, pendAny;

  assign busyOut   = (state != ST_IDLE);
  assign acceptReq = busyOut && dreq && !stopPending;
  assign stopNow   = stopPending || doneIn;
  assign pendAny   = pend || acceptReq;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    consume   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (startPulse && totalNonZero) begin
          strobe.load = 1'b1;
          stateNext   = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (pend) begin
          consume   = 1'b1;
          stateNext = needRefill ? ST_FETCH : ST_SEND;
        end else if (stopNow && !acceptReq) begin
          strobe.flush = 1'b1;
          stateNext    = ST_IDLE;
        end
      end
      ST_FETCH: begin
        // refill is always followed by its write: no stop check here
        if (busAck) begin
          strobe.fetchAck = 1'b1;
          stateNext       = ST_SEND;
        end
      end
      ST_SEND: begin
        if (busAck) begin
          strobe.sendAck = 1'b1;
          if (finalSend || (stopNow && !pendAny)) begin
            strobe.flush = 1'b1;
            stateNext    = ST_IDLE;
          end else begin
            stateNext = ST_WAIT;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    if (strobe.flush || !busyOut) pendNext = 1'b0;
    else                          pendNext = (pend && !consume) || acceptReq;
  end

  always_comb begin
    if (strobe.flush || !busyOut) stopNext = 1'b0;
    else                          stopNext = stopPending || doneIn;
  end

  assign busReq     = (state == ST_FETCH) || (state == ST_SEND);
  assign busMemRead = (state == ST_FETCH);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      pend        <= 1'b0;
      stopPending <= 1'b0;
    end else begin
      state       <= stateNext;
      pend        <= pendNext;
      stopPending <= stopNext;
    end
  end

endmodule

// File: rtl/dmaSeqTop.sv
module dmaSeqTop
  import dmaSeqPkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int MAX_SRC = 32,
  parameter int DST     = 4,
  localparam int XFER_W = $clog2(MAX_SRC + 1),
  localparam int OCC_W  = $clog2(MAX_SRC + DST)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic [CNT_W-1:0]  totalBytes,
  input  logic              dstDoneEn,
  input  logic              dreq,
  input  logic              doneIn,
  input  logic              busAck,
  output logic              busReq,
  output logic              busMemRead,
  output logic [XFER_W-1:0] busBytes,
  output logic              dack,
  output logic              dbb,
  output logic              doneOut,
  output logic              busyOut
);

  seqStrobe_t        strobe;
  logic [XFER_W-1:0] fetchBytes;
  logic [XFER_W-1:0] sendBytes;
  logic              needRefill;
  logic              finalSend;

  dmaSeqControl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .startPulse   (startPulse),
    .totalNonZero (totalBytes != '0),
    .dreq         (dreq),
    .doneIn       (doneIn),
    .busAck       (busAck),
    .needRefill   (needRefill),
    .finalSend    (finalSend),
    .strobe       (strobe),
    .busReq       (busReq),
    .busMemRead   (busMemRead),
    .busyOut      (busyOut)
  );

  dmaSeqDatapath #(
    .CNT_W   (CNT_W),
    .MAX_SRC (MAX_SRC),
    .DST     (DST),
    .XFER_W  (XFER_W),
    .OCC_W   (OCC_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .totalBytes (totalBytes),
    .fetchBytes (fetchBytes),
    .sendBytes  (sendBytes),
    .needRefill (needRefill),
    .finalSend  (finalSend)
  );

  assign busBytes = busMemRead ? fetchBytes : sendBytes;
  assign dbb      = busReq;
  assign dack     = busReq && !busMemRead;
  assign doneOut  = dack && finalSend && dstDoneEn;

endmodule

// File: rtl/dmaSeqChecker.sv
module dmaSeqChecker #(
  parameter int MAX_SRC = 32,
  parameter int XFER_W  = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              doneIn,
  input logic              busAck,
  input logic              busReq,
  input logic              busMemRead,
  input logic [XFER_W-1:0] busBytes,
  input logic              dack,
  input logic              dbb,
  input logic              doneOut,
  input logic              busyOut
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busyOut |-> !busReq && !dbb);  // R1

  AST_UNIT_WRITE_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busMemRead && busAck) |=> (busReq && !busMemRead && dack));  // R3

  AST_DACK_PERIPH_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    dack |-> dbb && !busMemRead);  // R5

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busAck) |=> busReq && $stable(busMemRead) && $stable(busBytes));  // R5

  AST_FETCH_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busMemRead) |-> (busBytes != '0) && (busBytes <= XFER_W'(MAX_SRC)));  // R6

  AST_FINAL_ENDS_RUN: assert property (@(posedge clk) disable iff (!rstN)
    (doneOut && busAck) |=> !busyOut);  // R7

  AST_DONE_NO_SPLIT: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busMemRead && doneIn) |=> busReq);  // R8

endmodule

bind dmaSeqTop dmaSeqChecker #(
  .MAX_SRC (MAX_SRC),
  .XFER_W  (XFER_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .doneIn     (doneIn),
  .busAck     (busAck),
  .busReq     (busReq),
  .busMemRead (busMemRead),
  .busBytes   (busBytes),
  .dack       (dack),
  .dbb        (dbb),
  .doneOut    (doneOut),
  .busyOut    (busyOut)
);

// File: tb/dmaSeqTop_tb.sv
module dmaSeqTop_tb;

  localparam int CNT_W  = 8;
  localparam int MSRC   = 8;
  localparam int DSZ    = 2;
  localparam int XW     = $clog2(MSRC + 1);
  localparam int LOGN   = 1024;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startPulse = 1'b0;
  logic [CNT_W-1:0] totalBytes = '0;
  logic          dstDoneEn = 1'b0;
  logic          dreq = 1'b0;
  logic          doneIn = 1'b0;
  logic          busAck = 1'b0;
  logic          busReq, busMemRead, dack, dbb, doneOut, busyOut;
  logic [XW-1:0] busBytes;

  int  checks = 0;
  int  fails  = 0;
  bit  holdAck = 1'b0;
  int  logCnt = 0;
  int  logBase = 0;
  bit  logMem  [LOGN];
  int  logBytes[LOGN];
  bit  logDack [LOGN];
  bit  logDone [LOGN];

  always #10 clk = ~clk;

  dmaSeqTop #(.CNT_W(CNT_W), .MAX_SRC(MSRC), .DST(DSZ)) u_dut (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .totalBytes(totalBytes),
    .dstDoneEn(dstDoneEn), .dreq(dreq), .doneIn(doneIn), .busAck(busAck),
    .busReq(busReq), .busMemRead(busMemRead), .busBytes(busBytes),
    .dack(dack), .dbb(dbb), .doneOut(doneOut), .busyOut(busyOut)
  );

  // Bus responder and transfer log
  always @(negedge clk) begin
    if (rstN && busReq && !busAck && !holdAck) begin
      logMem  [logCnt % LOGN] = busMemRead;
      logBytes[logCnt % LOGN] = int'(busBytes);
      logDack [logCnt % LOGN] = dack && dbb;
      logDone [logCnt % LOGN] = doneOut;
      logCnt = logCnt + 1;
      busAck = 1'b1;
    end else begin
      busAck = 1'b0;
    end
  end

  task automatic chkEq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int entries();
    return logCnt - logBase;
  endfunction

  task automatic clearLog();
    logBase = logCnt;
  endtask

  task automatic pulseDreq();
    @(posedge clk); #2 dreq = 1'b1;
    @(posedge clk); #2 dreq = 1'b0;
  endtask

  task automatic pulseDone();
    @(posedge clk); #2 doneIn = 1'b1;
    @(posedge clk); #2 doneIn = 1'b0;
  endtask

  task automatic pulseBoth();
    @(posedge clk); #2 begin dreq = 1'b1; doneIn = 1'b1; end
    @(posedge clk); #2 begin dreq = 1'b0; doneIn = 1'b0; end
  endtask

  task automatic waitNeg(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic startRun(input int t, input bit en);
    @(posedge clk); #2 begin totalBytes = CNT_W'(t); dstDoneEn = en; startPulse = 1'b1; end
    @(posedge clk); #2 startPulse = 1'b0;
    @(negedge clk);
    chkEq("R1 busy after start", int'(busyOut), 1);
  endtask

  task automatic drain();
    for (int k = 0; k < 40 && busyOut; k++) begin
      pulseDreq();
      waitNeg(8);
    end
  endtask

  task automatic checkEntry(input int i, input string tag, input bit mem, input int bytes,
                            input bit dk, input bit dn);
    int idx;
    idx = (logBase + i) % LOGN;
    chkEq({tag, " kind"},  int'(logMem[idx]),  int'(mem));
    chkEq({tag, " bytes"}, logBytes[idx],      bytes);
    chkEq({tag, " dack"},  int'(logDack[idx]), int'(dk));
    chkEq({tag, " done"},  int'(logDone[idx]), int'(dn));
  endtask

  // Full run of t bytes with one DREQ per unit, checked against occupancy model
  task automatic sweepRun(input int t, input bit en);
    int occ, fl, wr, w, f, idx, guard;
    occ = 0; fl = t; wr = t; guard = 0;
    startRun(t, en);
    while (wr > 0 && guard < 100) begin
      guard++;
      clearLog();
      pulseDreq();
      waitNeg(8);
      idx = 0;
      if (occ < DSZ && fl > 0) begin
        f = (fl < MSRC) ? fl : MSRC;
        checkEntry(0, (f < MSRC) ? "R6 short refill" : "R2 refill", 1'b1, f, 1'b0, 1'b0);
        occ += f; fl -= f; idx = 1;
      end
      w = (occ < DSZ) ? occ : DSZ;
      checkEntry(idx, (idx == 1) ? "R3 unit write" : "R4 plain write", 1'b0, w, 1'b1,
                 (wr == w) && en);
      occ -= w; wr -= w;
      chkEq("R5 transfers per dreq", entries(), idx + 1);
    end
    chkEq("R7 idle at end", int'(busyOut), 0);
  endtask

  initial begin
    waitNeg(3);
    chkEq("R1 reset busy", int'(busyOut), 0);
    chkEq("R1 reset busReq", int'(busReq), 0);
    chkEq("R1 reset dbb", int'(dbb), 0);
    chkEq("R1 reset dack", int'(dack), 0);
    chkEq("R1 reset doneOut", int'(doneOut), 0);
    @(posedge clk); #2 rstN = 1'b1;
    waitNeg(2);
    chkEq("R1 idle busReq", int'(busReq), 0);

    // Sweep of programmed counts
    for (int t = 1; t <= 21; t++) sweepRun(t, t[0]);

    // R9: stop while waiting, leftover discarded
    startRun(16, 1'b0);
    pulseDreq(); waitNeg(8);
    clearLog();
    pulseDone(); waitNeg(4);
    chkEq("R9 stopped", int'(busyOut), 0);
    chkEq("R9 no transfer", entries(), 0);
    startRun(4, 1'b1);
    clearLog();
    pulseDreq(); waitNeg(8);
    checkEntry(0, "R9 new run refills", 1'b1, 4, 1'b0, 1'b0);
    checkEntry(1, "R9 new run write", 1'b0, 2, 1'b1, 1'b0);
    drain();
    chkEq("R9 second run ends", int'(busyOut), 0);

    // R8: stop during memory read
    startRun(16, 1'b1);
    holdAck = 1'b1;
    clearLog();
    pulseDreq(); waitNeg(2);
    chkEq("R8 read outstanding", int'(busReq && busMemRead), 1);
    pulseDone();
    holdAck = 1'b0;
    waitNeg(8);
    chkEq("R8 entries", entries(), 2);
    checkEntry(0, "R8 read kept", 1'b1, 8, 1'b0, 1'b0);
    checkEntry(1, "R8 write kept", 1'b0, 2, 1'b1, 1'b0);
    chkEq("R8 stopped", int'(busyOut), 0);

    // R10: unserviced request raised during a write, then stop
    startRun(16, 1'b0);
    pulseDreq(); waitNeg(8);
    holdAck = 1'b1;
    clearLog();
    pulseDreq(); waitNeg(2);
    chkEq("R10 write outstanding", int'(busReq && !busMemRead), 1);
    pulseDreq();
    pulseDone();
    pulseDreq();
    holdAck = 1'b0;
    waitNeg(12);
    chkEq("R10 entries", entries(), 2);
    checkEntry(0, "R10 current write", 1'b0, 2, 1'b1, 1'b0);
    checkEntry(1, "R10 pending write", 1'b0, 2, 1'b1, 1'b0);
    chkEq("R10 stopped", int'(busyOut), 0);

    // R10: request and stop in the same cycle
    startRun(16, 1'b0);
    pulseDreq(); waitNeg(8);
    clearLog();
    pulseBoth(); waitNeg(8);
    chkEq("R10 same-cycle entries", entries(), 1);
    checkEntry(0, "R10 same-cycle write", 1'b0, 2, 1'b1, 1'b0);
    chkEq("R10 same-cycle stopped", int'(busyOut), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule